// File: doc/BRIEF.md
# PLL Divisor Search Engine

This block finds integer divider settings for a display clock synthesizer. Given a pixel clock and a reference frequency, it scales the pixel clock up by a DAC multiplier to form a target frequency. It then walks every combination of the feedback dividers (m1, m2), the input divider (n) and the post divider (p1), with p2 fixed at 10. It returns either the first setting whose output clock equals the target, or the legal setting that comes closest to the target from above.

Each candidate's feedback ratio is m = 5*(m1+2) + (m2+2) and its post ratio is p = p1*10. Its oscillator frequency is VCO = ref*m/(n+2), and its output clock is dot = VCO/p. Every frequency comparison is made by cross-multiplying integers, so the datapath has no divider. The engine tests one candidate per clock.

The controller has four states:
- IDLE: after reset. `start_i` moves it to SCALE.
- SCALE: forms the multiplier and the target. An illegal pixel clock moves it to HOLD; any other moves it to SCAN.
- SCAN: tests one candidate per clock. An exact match or the last candidate moves it to HOLD.
- HOLD: shows the results. `start_i` moves it back to SCALE.

Top module: `pll_divisor_search`

## Requirements
- R1: The multiplier is 1 when the pixel clock is at least 100,000,000 Hz, 2 when it is at least 50,000,000 Hz, and 4 otherwise. It is reported on `mult_o` as the binary value 1, 2 or 4. The target is the pixel clock times the multiplier.
- R2: A pixel clock below 25,000,000 Hz is illegal. No candidate is tested, `done_o` rises on the second rising edge counted from the edge that samples `start_i`, and `found_o` is 0.
- R3: When `found_o` is 1, the reported dividers lie in these ranges: n in 3..8, m1 in 10..20, m2 in 5..9 and p1 in 1..8. Also, m1 is strictly greater than m2.
- R4: A candidate is legal only if all of the following hold: m is in 70..120, p is in 5..80, the VCO is in 1.4 GHz..2.8 GHz, and the dot clock is in 20 MHz..400 MHz (all bounds inclusive).
- R5: Candidates are visited in a fixed order: n ascending (outermost), then m1 descending, then m2 descending, then p1 descending (innermost). The first legal candidate whose dot clock equals the target exactly ends the search. If it is candidate i (counting from 0), `done_o` rises on edge i+3.
- R6: When no candidate matches exactly, the result is the legal candidate whose dot clock is strictly above the target and closest to it. On equal error, the one visited first is kept.
- R7: When no legal candidate meets or overshoots the target, `found_o` is 0. `done_o` still rises, on edge 2642, after all 2640 candidates.
- R8: `div_word_o` holds (m2-2) in bits 7:0, (m1-2) in bits 15:8 and (n-2) in bits 23:16, with bits 31:24 at zero. The whole word is zero when `found_o` is 0.
- R9: The pixel and reference inputs are sampled only on the edge that accepts `start_i`. During SCAN, `start_i` and any change on those inputs have no effect.
- R10: After reset, `done_o`, `found_o`, `mult_o`, the divider outputs and `div_word_o` are all 0.
- R11: In HOLD, `done_o` stays 1 and all result outputs stay stable until `start_i` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a search when idle or holding |
| ref_hz_i | input | 32 | Reference frequency in Hz |
| pix_hz_i | input | 32 | Pixel clock in Hz |
| done_o | output | 1 | Search finished; results valid |
| found_o | output | 1 | A setting was chosen |
| mult_o | output | 3 | DAC multiplier (1, 2 or 4) |
| n_o | output | 4 | Chosen n |
| m1_o | output | 5 | Chosen m1 |
| m2_o | output | 4 | Chosen m2 |
| p1_o | output | 4 | Chosen p1 |
| div_word_o | output | 32 | Packed divisor word |

## Verification
Some properties are checked by assertions on every cycle:
- the range of the chosen dividers and of m, and the ordering m1 > m2;
- the step-by-step descent of p1 and the carry into n during the walk;
- the shortcut from SCALE to HOLD for an illegal pixel clock;
- that `start_i` is ignored during SCAN;
- that the results do not move while in HOLD.

Other properties are shown only by the bench scenarios, which compare each result against an independent search run over the same limits. These are:
- which candidate wins (exact match versus closest overshoot, and ties);
- the multiplier thresholds at their exact boundary values;
- the completion latency for an exact hit and for an exhausted search.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

    localparam int NW  = 4;
    localparam int M1W = 5;
    localparam int M2W = 4;
    localparam int P1W = 4;

    localparam logic [NW-1:0]  N_MIN  = NW'(3);
    localparam logic [NW-1:0]  N_MAX  = NW'(8);
    localparam logic [M1W-1:0] M1_MIN = M1W'(10);
    localparam logic [M1W-1:0] M1_MAX = M1W'(20);
    localparam logic [M2W-1:0] M2_MIN = M2W'(5);
    localparam logic [M2W-1:0] M2_MAX = M2W'(9);
    localparam logic [P1W-1:0] P1_MIN = P1W'(1);
    localparam logic [P1W-1:0] P1_MAX = P1W'(8);
    localparam logic [7:0]     P2_FIX = 8'd10;

    localparam logic [7:0]  M_LO = 8'd70;
    localparam logic [7:0]  M_HI = 8'd120;
    localparam logic [7:0]  P_LO = 8'd5;
    localparam logic [7:0]  P_HI = 8'd80;
    localparam logic [63:0] DOT_LO = 64'd20_000_000;
    localparam logic [63:0] DOT_HI = 64'd400_000_000;
    localparam logic [63:0] VCO_LO = 64'd1_400_000_000;
    localparam logic [63:0] VCO_HI = 64'd2_800_000_000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCALE,
        ST_SCAN,
        ST_HOLD
    } srch_state_e;

    typedef struct packed {
        logic [NW-1:0]  n;
        logic [M1W-1:0] m1;
        logic [M2W-1:0] m2;
        logic [P1W-1:0] p1;
    } pll_div_t;

endpackage

// File: rtl/pll_tgt_scale.sv
module pll_tgt_scale #(
    parameter int FW = 32,
    parameter int TW = FW + 2,
    parameter logic [FW-1:0] PIX_HI = FW'(100_000_000),
    parameter logic [FW-1:0] PIX_MID = FW'(50_000_000),
    parameter logic [FW-1:0] PIX_LO = FW'(25_000_000)
) (
    input  logic [FW-1:0] pix_hz,
    output logic [2:0]    mult,
    output logic [TW-1:0] target,
    output logic          illegal
);

    always_comb begin
        if (pix_hz >= PIX_HI) begin
            mult = 3'd1;
        end else if (pix_hz >= PIX_MID) begin
            mult = 3'd2;
        end else begin
            mult = 3'd4;
        end
        illegal = (pix_hz < PIX_LO);
        target  = TW'(pix_hz) * TW'(mult);
    end

endmodule

// File: rtl/pll_div_walk.sv
module pll_div_walk
    import pll_srch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  logic     step,
    output pll_div_t cand,
    output logic     last
);

    localparam pll_div_t FIRST = '{n: N_MIN, m1: M1_MAX, m2: M2_MAX, p1: P1_MAX};

    logic p1_wrap, m2_wrap, m1_wrap;

    always_comb begin
        p1_wrap = (cand.p1 == P1_MIN);
        m2_wrap = (cand.m2 == M2_MIN);
        m1_wrap = (cand.m1 == M1_MIN);
        last    = p1_wrap && m2_wrap && m1_wrap && (cand.n == N_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand <= FIRST;
        end else if (load) begin
            cand <= FIRST;
        end else if (step && !last) begin
            if (!p1_wrap) begin
                cand.p1 <= cand.p1 - P1W'(1);
            end else begin
                cand.p1 <= P1_MAX;
                if (!m2_wrap) begin
                    cand.m2 <= cand.m2 - M2W'(1);
                end else begin
                    cand.m2 <= M2_MAX;
                    if (!m1_wrap) begin
                        cand.m1 <= cand.m1 - M1W'(1);
                    end else begin
                        cand.m1 <= M1_MAX;
                        cand.n  <= cand.n + NW'(1);
                    end
                end
            end
        end
    end

    // R5
    p1_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !p1_wrap) |=> (cand.p1 == $past(cand.p1) - P1W'(1)));

    // R5
    n_asc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && p1_wrap && m2_wrap && m1_wrap && !last)
            |=> (cand.n == $past(cand.n) + NW'(1)) && (cand.m1 == M1_MAX));

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
    import pll_srch_pkg::*;
#(
    parameter int FW = 32,
    parameter int TW = FW + 2
) (
    input  pll_div_t      cand,
    input  logic [FW-1:0] ref_hz,
    input  logic [TW-1:0] target,
    input  logic          best_ok,
    input  logic [7:0]    best_m,
    input  logic [9:0]    best_den,
    output logic          legal,
    output logic          exact,
    output logic          better,
    output logic [7:0]    m_val,
    output logic [9:0]    den
);

    logic [7:0]  np2, p_val;
    logic [63:0] ref_m, tgt_den, vco_den_lo, vco_den_hi;
    logic        div_ok, der_ok, freq_ok, over, closer;

    always_comb begin
        m_val   = 8'd5 * (8'(cand.m1) + 8'd2) + 8'(cand.m2) + 8'd2;
        np2     = 8'(cand.n) + 8'd2;
        p_val   = 8'(cand.p1) * P2_FIX;
        den     = 10'(np2) * 10'(p_val);
        ref_m   = 64'(ref_hz) * 64'(m_val);
        tgt_den = 64'(target) * 64'(den);
        vco_den_lo = VCO_LO * 64'(np2);
        vco_den_hi = VCO_HI * 64'(np2);

        div_ok = (cand.n >= N_MIN) && (cand.n <= N_MAX)
              && (cand.m1 >= M1_MIN) && (cand.m1 <= M1_MAX)
              && (cand.m2 >= M2_MIN) && (cand.m2 <= M2_MAX)
              && (cand.p1 >= P1_MIN) && (cand.p1 <= P1_MAX)
              && (5'(cand.m2) < cand.m1);
        der_ok = (m_val >= M_LO) && (m_val <= M_HI)
              && (p_val >= P_LO) && (p_val <= P_HI);
        freq_ok = (ref_m >= DOT_LO * 64'(den)) && (ref_m <= DOT_HI * 64'(den))
               && (ref_m >= vco_den_lo) && (ref_m <= vco_den_hi);

        legal  = div_ok && der_ok && freq_ok;
        exact  = legal && (ref_m == tgt_den);
        over   = ref_m > tgt_den;
        closer = (64'(m_val) * 64'(best_den)) < (64'(best_m) * 64'(den));
        better = legal && over && (!best_ok || closer);
    end

endmodule

// File: rtl/pll_divisor_search.sv
module pll_divisor_search
    import pll_srch_pkg::*;
#(
    parameter int FW = 32,
    parameter int WW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [FW-1:0]  ref_hz_i,
    input  logic [FW-1:0]  pix_hz_i,
    output logic           done_o,
    output logic           found_o,
    output logic [2:0]     mult_o,
    output logic [NW-1:0]  n_o,
    output logic [M1W-1:0] m1_o,
    output logic [M2W-1:0] m2_o,
    output logic [P1W-1:0] p1_o,
    output logic [WW-1:0]  div_word_o
);

    localparam int TW = FW + 2;

    srch_state_e state, state_nx;

    logic [FW-1:0] pix_q, ref_q;
    logic [TW-1:0] tgt_q, tgt_w;
    logic [2:0]    mult_q, mult_w;
    logic          illegal_w;
    pll_div_t      cand, best;
    logic          last_w, best_ok;
    logic [7:0]    best_m, m_w;
    logic [9:0]    best_den, den_w;
    logic          legal_w, exact_w, better_w;

    pll_tgt_scale #(.FW(FW), .TW(TW)) u_scale (
        .pix_hz  (pix_q),
        .mult    (mult_w),
        .target  (tgt_w),
        .illegal (illegal_w)
    );

    pll_div_walk u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == ST_SCALE),
        .step  (state == ST_SCAN),
        .cand  (cand),
        .last  (last_w)
    );

    pll_cand_eval #(.FW(FW), .TW(TW)) u_eval (
        .cand     (cand),
        .ref_hz   (ref_q),
        .target   (tgt_q),
        .best_ok  (best_ok),
        .best_m   (best_m),
        .best_den (best_den),
        .legal    (legal_w),
        .exact    (exact_w),
        .better   (better_w),
        .m_val    (m_w),
        .den      (den_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_HOLD: if (start_i) state_nx = ST_SCALE;
            ST_SCALE:         state_nx = illegal_w ? ST_HOLD : ST_SCAN;
            ST_SCAN:          if (exact_w || last_w) state_nx = ST_HOLD;
            default:          state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q    <= '0;
            ref_q    <= '0;
            tgt_q    <= '0;
            mult_q   <= '0;
            best     <= '0;
            best_ok  <= 1'b0;
            best_m   <= '0;
            best_den <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_HOLD: begin
                    if (start_i) begin
                        pix_q   <= pix_hz_i;
                        ref_q   <= ref_hz_i;
                        best    <= '0;
                        best_ok <= 1'b0;
                    end
                end
                ST_SCALE: begin
                    tgt_q  <= tgt_w;
                    mult_q <= mult_w;
                end
                ST_SCAN: begin
                    if (exact_w || better_w) begin
                        best     <= cand;
                        best_ok  <= 1'b1;
                        best_m   <= m_w;
                        best_den <= den_w;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done_o  = (state == ST_HOLD);
        found_o = best_ok;
        mult_o  = mult_q;
        n_o     = best.n;
        m1_o    = best.m1;
        m2_o    = best.m2;
        p1_o    = best.p1;
        div_word_o = '0;
        if (best_ok) begin
            div_word_o = WW'({8'(best.n) - 8'd2, 8'(best.m1) - 8'd2, 8'(best.m2) - 8'd2});
        end
    end

    // R3
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && found_o) |-> (n_o >= N_MIN) && (n_o <= N_MAX)
            && (m1_o >= M1_MIN) && (m1_o <= M1_MAX) && (m2_o >= M2_MIN)
            && (m2_o <= M2_MAX) && (p1_o >= P1_MIN) && (p1_o <= P1_MAX)
            && (5'(m2_o) < m1_o));

    // R4
    m_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && found_o) |-> (best_m >= M_LO) && (best_m <= M_HI));

    // R2
    illegal_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCALE && illegal_w) |=> (done_o && !found_o));

    // R1
    mult_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(mult_o) == 1));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && start_i) |=> (state != ST_SCALE));

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(div_word_o)
            && $stable(found_o) && $stable(mult_o) && $stable(p1_o)));

endmodule

// File: tb/test_pll_divisor_search.sv
module test_pll_divisor_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ref_hz_i = '0;
    logic [31:0] pix_hz_i = '0;
    logic        done_o, found_o;
    logic [2:0]  mult_o;
    logic [3:0]  n_o, m2_o, p1_o;
    logic [4:0]  m1_o;
    logic [31:0] div_word_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pll_divisor_search i_pll_divisor_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_hz_i(ref_hz_i),
        .pix_hz_i(pix_hz_i), .done_o(done_o), .found_o(found_o), .mult_o(mult_o),
        .n_o(n_o), .m1_o(m1_o), .m2_o(m2_o), .p1_o(p1_o), .div_word_o(div_word_o)
    );

    localparam int NV = 11;
    localparam longint VPIX [NV] = '{25_175_000, 65_000_000, 108_000_000, 192_000_000,
        450_000_000, 50_000_000, 99_999_999, 100_000_000, 24_999_999, 25_000_000, 148_500_000};
    localparam longint VREF [NV] = '{96_000_000, 96_000_000, 96_000_000, 96_000_000,
        96_000_000, 96_000_000, 96_000_000, 100_000_000, 96_000_000, 10_000_000, 96_000_000};
    localparam int VMULT [NV] = '{4, 2, 1, 1, 1, 2, 2, 1, 4, 4, 1};

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // independent search over the requirement limits
    task automatic model(input longint pix, input longint rf, output bit fnd,
                         output int bn, output int bm1, output int bm2, output int bp1,
                         output int lat);
        longint tgt, m, d, lhs, bmv, bdv;
        bit have;
        int idx;
        int mult;
        fnd = 0; bn = 0; bm1 = 0; bm2 = 0; bp1 = 0;
        if (pix < 25_000_000) begin
            lat = 2;
            return;
        end
        mult = (pix >= 100_000_000) ? 1 : (pix >= 50_000_000) ? 2 : 4;
        tgt = pix * mult;
        have = 0; idx = 0; bmv = 0; bdv = 0;
        for (int n = 3; n <= 8; n++)
            for (int m1 = 20; m1 >= 10; m1--)
                for (int m2 = 9; m2 >= 5; m2--)
                    for (int p1 = 8; p1 >= 1; p1--) begin
                        m = 5 * (m1 + 2) + (m2 + 2);
                        d = (n + 2) * p1 * 10;
                        lhs = rf * m;
                        if (m1 > m2 && m >= 70 && m <= 120 && p1 * 10 >= 5 && p1 * 10 <= 80
                            && lhs >= 64'd20_000_000 * d && lhs <= 64'd400_000_000 * d
                            && lhs >= 64'd1_400_000_000 * (n + 2)
                            && lhs <= 64'd2_800_000_000 * (n + 2)) begin
                            if (lhs == tgt * d) begin
                                fnd = 1; bn = n; bm1 = m1; bm2 = m2; bp1 = p1;
                                lat = idx + 3;
                                return;
                            end
                            if (lhs > tgt * d && (!have || m * bdv < bmv * d)) begin
                                have = 1; bmv = m; bdv = d;
                                bn = n; bm1 = m1; bm2 = m2; bp1 = p1;
                            end
                        end
                        idx++;
                    end
        fnd = have;
        lat = 2642;
    endtask

    task automatic run(input longint pix, input longint rf, input int exp_mult, input bit mid_start);
        bit fnd;
        int en, em1, em2, ep1, elat, cyc;
        longint word;
        model(pix, rf, fnd, en, em1, em2, ep1, elat);
        @(negedge clk);
        pix_hz_i = 32'(pix);
        ref_hz_i = 32'(rf);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 4000) begin
            if (mid_start && cyc == 10) begin
                // R9: restart attempt and input change during SCAN
                start_i = 1'b1;
                pix_hz_i = 32'd108_000_000;
                ref_hz_i = 32'd50_000_000;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        // R2 R5 R7 latency
        check(cyc == elat, "R5/R7/R2 latency", cyc, elat);
        // R1
        check(int'(mult_o) == exp_mult, "R1 multiplier", mult_o, exp_mult);
        // R6 selection
        check(found_o == fnd, "R6 found", found_o, fnd);
        if (fnd) begin
            check(int'(n_o) == en && int'(m1_o) == em1 && int'(m2_o) == em2 && int'(p1_o) == ep1,
                  "R6 dividers", {n_o, m1_o, m2_o, p1_o}, {4'(en), 5'(em1), 4'(em2), 4'(ep1)});
            // R3
            check(m1_o > 5'(m2_o) && n_o >= 3 && n_o <= 8, "R3 ranges", m1_o, m2_o);
            // R4
            check(5 * (int'(m1_o) + 2) + int'(m2_o) + 2 <= 120
                  && 5 * (int'(m1_o) + 2) + int'(m2_o) + 2 >= 70, "R4 m range", m1_o, m2_o);
            word = longint'(em2 - 2) | (longint'(em1 - 2) << 8) | (longint'(en - 2) << 16);
        end else begin
            word = 0;
        end
        // R8
        check(longint'(div_word_o) == word, "R8 word", div_word_o, word);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] w0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!done_o && !found_o && mult_o == 0 && div_word_o == 0 && n_o == 0 && p1_o == 0,
              "R10 reset", {done_o, found_o, mult_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) run(VPIX[i], VREF[i], VMULT[i], 1'b0);
        // R9 start ignored while scanning
        run(65_000_000, 96_000_000, 2, 1'b1);
        // R11 hold stability
        w0 = div_word_o;
        repeat (25) @(negedge clk);
        check(done_o && div_word_o == w0 && found_o, "R11 hold", div_word_o, w0);
        // back-to-back after hold
        run(192_000_000, 96_000_000, 1, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule